// File: doc/BRIEF.md
# Double-Buffered Serial Bit Transmitter

This block turns bytes written by a host into a serial bit stream at a programmable rate. It has a pair of byte registers that work as a two-deep queue. The byte at the head is shifted out most significant bit first. Meanwhile the host can refill the other register, so consecutive bytes leave with no gap between them.

The bit period comes from two stages. A fixed prescaler first divides the reference clock into a base tick. A second counter then counts `(rate_r+1)` base ticks per bit, or eight times that many when `rate_slow` is set.

The ready flag tells the host that a register is free. After enable, both registers hold the pattern 0xAA, so every transmission begins with a 16-bit alternating preamble. A write made while both registers are occupied is discarded and leaves a sticky overrun flag. Dropping `en` stops the shifter and reloads the preamble.

Top module: `txdb_serial_tx`

## Requirements
- R1: While `en` is low after reset, both registers hold 0xAA. In that state `ready`, `bit_stb`, `tx_bit` and `overrun` are all 0.
- R2: Each byte is sent most significant bit first. `bit_stb` is high for exactly one clock, in the last clock of each bit period. During that clock `tx_bit` carries the bit that is ending.
- R3: While data flows, one bit period lasts `BASE_DIV*(rate_r+1)*(rate_slow ? 8 : 1)` clock cycles.
- R4: After `en` rises, two bytes of 0xAA (bits 1,0,1,0,...) are sent before any byte the host writes.
- R5: `ready` is high exactly when at least one of the two registers is free. It is low while both preamble bytes are pending, and it goes high in the clock after the first byte's final strobe.
- R6: A byte written in a clock where `ready` is high (with `wr_en` held for that one clock) is sent after the bytes already queued, in write order. Bytes queued together are sent back to back, with no idle clock between the last bit of one byte and the first bit of the next.
- R7: A write in a clock where `ready` is low is discarded. It sets `overrun`, which then stays high until `rst_n` is asserted. Dropping `en` does not clear it.
- R8: When both registers are empty, no strobe occurs and `tx_bit` is 0. A later write starts a fresh bit period, so its first strobe comes `P-1` clocks after the write edge, where `P` is the period from R3.
- R9: Lowering `en` stops shifting at once and discards every queued byte. Both registers are reloaded with 0xAA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Transmit enable; low reloads the preamble |
| wr_en | input | 1 | One-clock byte write strobe |
| wr_data | input | 8 | Byte to queue |
| rate_r | input | 7 | Rate divisor minus one, in base ticks |
| rate_slow | input | 1 | Multiplies the bit period by eight |
| tx_bit | output | 1 | Serial data, most significant bit first |
| bit_stb | output | 1 | High in the last clock of each bit |
| ready | output | 1 | A byte register is free |
| overrun | output | 1 | Sticky: a write was dropped |

## Verification
The stream is tried with the preamble alone, with asymmetric bytes (0x3C, 0xF0, 0x01, 0x80, 0xC3, 0x5A, 0x96, 0x69), and with a write pushed into a full queue. Bytes such as 0x01 and 0x80 distinguish MSB-first from LSB-first order and expose any bit slip. The dropped 0x55 would appear in the scoreboard if an overfull write leaked through. Strobe spacing is measured at three rate settings, including the slow prescale, while bytes run back to back; this separates a wrong period formula from a gap between bytes. Idle restart and a mid-byte disable show fresh-period timing and preamble reload, with the discarded data never appearing.

// File: rtl/txdb_pkg.sv
package txdb_pkg;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = $clog2(BYTE_W);
    localparam int RATE_W   = 7;
    localparam int SLOW_MUL = 8;
    localparam int TICKS_W  = RATE_W + $clog2(SLOW_MUL) + 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t [1:0]      slot;
        logic  [1:0]      fill;
        logic  [IDX_W-1:0] idx;
        logic             ovr;
    } pair_st_t;

    function automatic logic [TICKS_W-1:0] ticks_per_bit(
        input logic [RATE_W-1:0] r,
        input logic              slow
    );
        logic [TICKS_W-1:0] base;
        base = TICKS_W'(r) + TICKS_W'(1);
        return slow ? base * TICKS_W'(SLOW_MUL) : base;
    endfunction
endpackage

// File: rtl/txdb_rate_gen.sv
module txdb_rate_gen
    import txdb_pkg::*;
#(
    parameter int BASE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_r,
    input  logic              rate_slow,
    output logic              bit_end
);
    localparam int PRE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BASE_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [TICKS_W-1:0] cnt;
    } rg_st_t;

    rg_st_t rg_d, rg_q;
    logic [TICKS_W-1:0] last_tick;
    logic               end_c;

    always_comb begin
        last_tick = ticks_per_bit(rate_r, rate_slow) - TICKS_W'(1);
        end_c     = run && (rg_q.pre == PRE_LAST) && (rg_q.cnt >= last_tick);
        rg_d      = rg_q;
        if (!run) begin
            rg_d = '0;
        end else if (rg_q.pre == PRE_LAST) begin
            rg_d.pre = '0;
            rg_d.cnt = end_c ? '0 : rg_q.cnt + TICKS_W'(1);
        end else begin
            rg_d.pre = rg_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign bit_end = end_c;

    // a new run always starts from a cleared divider (fresh period)
    assert_fresh_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (rg_q == '0));

    // a bit is at least two clocks long, so strobes never touch
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !bit_end);
endmodule

// File: rtl/txdb_byte_pair.sv
module txdb_byte_pair
    import txdb_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PRELOAD = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              bit_end,
    output logic              head_bit,
    output logic              busy,
    output logic              ready,
    output logic              overrun
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

    pair_st_t bp_d, bp_q;
    logic     pop;

    always_comb begin
        bp_d = bp_q;
        pop  = bit_end && (bp_q.idx == IDX_LAST);
        if (!en) begin
            bp_d.slot[0] = PRELOAD;
            bp_d.slot[1] = PRELOAD;
            bp_d.fill    = 2'd2;
            bp_d.idx     = '0;
        end else begin
            if (bit_end) bp_d.idx = pop ? '0 : bp_q.idx + IDX_W'(1);
            if (pop) begin
                bp_d.slot[0] = bp_q.slot[1];
                bp_d.fill    = bp_q.fill - 2'd1;
            end
            if (wr_en) begin
                if (bp_q.fill != 2'd2) begin
                    if (bp_d.fill == 2'd0) bp_d.slot[0] = wr_data;
                    else                   bp_d.slot[1] = wr_data;
                    bp_d.fill = bp_d.fill + 2'd1;
                end else begin
                    bp_d.ovr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_q.slot[0] <= PRELOAD;
            bp_q.slot[1] <= PRELOAD;
            bp_q.fill    <= 2'd2;
            bp_q.idx     <= '0;
            bp_q.ovr     <= 1'b0;
        end else begin
            bp_q <= bp_d;
        end
    end

    assign head_bit = bp_q.slot[0][IDX_LAST - bp_q.idx];
    assign busy     = en && (bp_q.fill != 2'd0);
    assign ready    = en && (bp_q.fill != 2'd2);
    assign overrun  = bp_q.ovr;

    assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (bp_q.fill == 2'd2 && bp_q.idx == '0 &&
                 bp_q.slot[0] == PRELOAD && bp_q.slot[1] == PRELOAD));

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bp_q.ovr |=> bp_q.ovr);

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en && bp_q.fill == 2'd2 && !bit_end) |=> (bp_q.fill == 2'd2));
endmodule

// File: rtl/txdb_serial_tx.sv
module txdb_serial_tx
    import txdb_pkg::*;
#(
    parameter int                BASE_DIV = 4,
    parameter logic [BYTE_W-1:0] PRELOAD  = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [RATE_W-1:0] rate_r,
    input  logic              rate_slow,
    output logic              tx_bit,
    output logic              bit_stb,
    output logic              ready,
    output logic              overrun
);
    logic busy;
    logic head_bit;
    logic bit_end;

    txdb_rate_gen #(.BASE_DIV(BASE_DIV)) i_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .rate_r    (rate_r),
        .rate_slow (rate_slow),
        .bit_end   (bit_end)
    );

    txdb_byte_pair #(.PRELOAD(PRELOAD)) i_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .bit_end  (bit_end),
        .head_bit (head_bit),
        .busy     (busy),
        .ready    (ready),
        .overrun  (overrun)
    );

    assign tx_bit  = busy && head_bit;
    assign bit_stb = bit_end;

    assert_stb_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> (en && busy));
endmodule

// File: tb/test_txdb_serial_tx.sv
module test_txdb_serial_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [6:0] rate_r = 7'd0;
    logic       rate_slow = 1'b0;
    logic       tx_bit, bit_stb, ready, overrun;

    localparam int BD = 4;

    always #4 clk = ~clk;

    txdb_serial_tx #(.BASE_DIV(BD)) i_txdb_serial_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
        .rate_r(rate_r), .rate_slow(rate_slow),
        .tx_bit(tx_bit), .bit_stb(bit_stb), .ready(ready), .overrun(overrun)
    );

    int     checks = 0;
    int     fails = 0;
    longint cyc = 0;
    int     strobes = 0;
    longint last_stb = 0;
    longint first_stb = 0;
    longint write_cyc = 0;
    int     exp_gap = BD;
    bit     skip_gap = 1'b1;
    bit     finished = 1'b0;
    bit     exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop scoreboard on each strobe, check bit and spacing
    always @(negedge clk) begin
        if (rst_n && bit_stb) begin
            if (skip_gap) begin
                skip_gap = 1'b0;
                first_stb = cyc;
            end else begin
                chk((cyc - last_stb) == exp_gap, "R3/R6", "strobe spacing",
                    cyc - last_stb, exp_gap);
            end
            last_stb = cyc;
            strobes++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected strobe", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(tx_bit == e, "R2", "serial bit", tx_bit, e);
            end
        end
    end

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    task automatic wr(input logic [7:0] b, output bit accepted);
        @(posedge clk); #2;
        accepted = ready;
        wr_en = 1'b1;
        wr_data = b;
        @(posedge clk); #2;
        write_cyc = cyc;
        wr_en = 1'b0;
        if (accepted) push_byte(b);
    endtask

    task automatic wait_strobes(input int n);
        int target;
        target = strobes + n;
        while (strobes < target) @(negedge clk);
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic enable_on();
        @(posedge clk); #2;
        exp_q.delete();
        push_byte(8'hAA);
        push_byte(8'hAA);
        skip_gap = 1'b1;
        en = 1'b1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        summary();
    end

    initial begin
        bit acc;
        int s0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0, "R1", "ready while disabled", ready, 0);
        chk(bit_stb == 1'b0, "R1", "strobe while disabled", bit_stb, 0);
        chk(tx_bit == 1'b0, "R1", "tx_bit while disabled", tx_bit, 0);
        chk(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);

        // R4: preamble first, R5: ready timing
        exp_gap = BD;
        enable_on();
        wait_strobes(1);
        chk(ready == 1'b0, "R5", "ready with both full", ready, 0);
        wait_strobes(7);
        @(negedge clk);
        chk(ready == 1'b1, "R5", "ready after first byte", ready, 1);
        wr(8'h3C, acc);
        chk(acc == 1'b1, "R6", "write accepted", acc, 1);
        @(negedge clk);
        chk(ready == 1'b0, "R5", "ready after refill", ready, 0);
        wait_ready();
        wr(8'hF0, acc);
        chk(acc == 1'b1, "R6", "write accepted", acc, 1);
        // R7: write into full pair is dropped
        wr(8'h55, acc);
        chk(acc == 1'b0, "R7", "ready low when full", acc, 0);
        @(negedge clk);
        chk(overrun == 1'b1, "R7", "overrun set", overrun, 1);
        wait_ready();
        wr(8'h01, acc);
        wait_ready();
        wr(8'h80, acc);
        wait_drain();

        // R8: idle, no strobes, tx_bit low
        s0 = strobes;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (k % 20 == 0) chk(tx_bit == 1'b0, "R8", "idle tx_bit", tx_bit, 0);
        end
        chk(strobes == s0, "R8", "no strobe when empty", strobes, s0);
        chk(overrun == 1'b1, "R7", "overrun sticky", overrun, 1);

        // R3: medium rate, R8: fresh period after idle
        rate_r = 7'd2;
        exp_gap = BD * 3;
        skip_gap = 1'b1;
        wr(8'hC3, acc);
        s0 = int'(write_cyc);
        wait_strobes(1);
        chk(first_stb - s0 == exp_gap - 1, "R8", "first strobe delay",
            first_stb - s0, exp_gap - 1);
        wait_ready();
        wr(8'h5A, acc);
        wait_drain();

        // R3: slow prescale
        rate_r = 7'd1;
        rate_slow = 1'b1;
        exp_gap = BD * 2 * 8;
        skip_gap = 1'b1;
        wr(8'h96, acc);
        wait_ready();
        wr(8'h69, acc);
        wait_drain();

        // R9: disable mid-byte discards queue and reloads preamble
        rate_r = 7'd0;
        rate_slow = 1'b0;
        exp_gap = BD;
        skip_gap = 1'b1;
        wr(8'h11, acc);
        wr(8'h22, acc);
        wait_strobes(3);
        @(posedge clk); #2;
        en = 1'b0;
        exp_q.delete();
        @(negedge clk);
        chk(tx_bit == 1'b0, "R9", "tx_bit after disable", tx_bit, 0);
        chk(ready == 1'b0, "R9", "ready after disable", ready, 0);
        s0 = strobes;
        repeat (20) @(negedge clk);
        chk(strobes == s0, "R9", "no strobe while disabled", strobes, s0);
        chk(overrun == 1'b1, "R7", "overrun survives disable", overrun, 1);
        enable_on();
        wait_strobes(16);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "only preamble after re-enable", exp_q.size(), 0);

        // R7: reset clears overrun
        @(posedge clk); #2;
        rst_n = 1'b0;
        en = 1'b0;
        exp_q.delete();
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(overrun == 1'b0, "R7", "overrun cleared by reset", overrun, 0);

        summary();
    end
endmodule